// File: doc/BRIEF.md
# I2C Byte-Memory Target with Persistent Address Pointer

This block is a two-wire serial bus target that sits in front of a 256-entry, 8-bit internal memory. It watches already-synchronised SCL and SDA inputs and finds Start, repeated Start and Stop conditions. It then decodes a control byte whose upper seven bits select the device and whose lowest bit chooses the direction. The only output is an open-drain style pull-down enable for SDA.

A write transfer carries a word address and then any number of data bytes, which are stored one after another. A read transfer streams bytes out of the memory. One address pointer lives across transactions and serves every form of read. A current-address read continues from wherever the last access stopped. A random read loads the pointer in a short write phase that a repeated Start cuts off, and then reads from that address. In a sequential read, the master's acknowledge after each byte requests the next byte. The pointer wraps from the top of the memory to zero.

Top module: `i2c_mem_target`

## Requirements
- R1: The target acknowledges a control byte only when its upper seven bits equal the parameter DEV_ADDR (default 7'h50). For any other value it leaves SDA released until the next Start, writes nothing and leaves the pointer unchanged.
- R2: With the direction bit 0, the first byte after the control byte loads the address pointer and is acknowledged.
- R3: In a write transfer, each later byte is stored at the pointer and acknowledged, and the pointer then steps by one.
- R4: With the direction bit 1, the target acknowledges and then shifts out the byte at the pointer, most significant bit first. The pointer then steps by one.
- R5: A read that starts without a write phase returns the byte that follows the last location written or read.
- R6: A repeated Start after the word address ends the write phase and keeps the loaded pointer, so the next read returns the byte at that address.
- R7: A master acknowledge (SDA low in the ninth clock) makes the target send the next sequential byte. A master non-acknowledge makes it release SDA and send nothing more before the next Start.
- R8: Stepping the pointer past 8'hFF gives 8'h00, for both writes and reads.
- R9: SDA drive changes only while SCL is low. Drive stays stable through each SCL high phase, except that a Start or Stop releases it.
- R10: A Start or Stop in the middle of a byte ends the transfer and releases SDA. The partial byte is not stored, and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (resolved bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
On every cycle the assertions check four things. The SDA enable never changes during an SCL high phase except when a Start or Stop releases it. Each pointer step equals the old value plus one, modulo 256. The pointer does not move in the cycle after a Start. SDA stays released after a Stop and while the target ignores a transfer addressed to another device. Only the bench scenarios can show the values on the bus: acknowledge bits, streamed bytes, current-address continuity, random reads after a repeated Start, wrap-around in both directions, and aborted bytes that leave memory unchanged.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK, ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {
    NX_ADDR, NX_WDATA, NX_RDATA
  } ack_next_e;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = !scl_q && scl_i;
  assign scl_fall  = scl_q && !scl_i;
  // data edges while the clock stays high mark bus conditions
  assign start_det = scl_q && scl_i && sda_q && !sda_i;
  assign stop_det  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2c_mem_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic scl_rise, scl_fall, start_det, stop_det;

  tgt_state_e        state_q, state_d;
  ack_next_e         nxt_q, nxt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic              mack_q, mack_d;
  logic              ptr_step;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;

  i2c_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (ptr_q),
    .wdata (sreg_q),
    .rdata (mem_rdata)
  );

  always_comb begin
    state_d  = state_q;
    nxt_d    = nxt_q;
    cnt_d    = cnt_q;
    sreg_d   = sreg_q;
    ptr_d    = ptr_q;
    oe_d     = oe_q;
    mack_d   = mack_q;
    ptr_step = 1'b0;
    mem_we   = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_CTRL;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sreg_d = {sreg_q[DATA_W-2:0], sda_i};
            cnt_d  = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (state_q == ST_CTRL) begin
              if (sreg_q[7:1] == DEV_ADDR) begin
                oe_d    = 1'b1;
                state_d = ST_ACK;
                nxt_d   = sreg_q[0] ? NX_RDATA : NX_ADDR;
              end else begin
                state_d = ST_IGNORE;
              end
            end else if (state_q == ST_ADDR) begin
              ptr_d   = sreg_q[ADDR_W-1:0];
              oe_d    = 1'b1;
              state_d = ST_ACK;
              nxt_d   = NX_WDATA;
            end else begin
              mem_we   = 1'b1;
              ptr_step = 1'b1;
              oe_d     = 1'b1;
              state_d  = ST_ACK;
              nxt_d    = NX_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            unique case (nxt_q)
              NX_ADDR:  state_d = ST_ADDR;
              NX_WDATA: state_d = ST_WDATA;
              default: begin
                sreg_d   = mem_rdata;
                oe_d     = !mem_rdata[DATA_W-1];
                ptr_step = 1'b1;
                cnt_d    = '0;
                state_d  = ST_RDATA;
              end
            endcase
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              cnt_d  = cnt_q + 1'b1;
              sreg_d = {sreg_q[DATA_W-2:0], 1'b0};
              oe_d   = !sreg_q[DATA_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = !sda_i;
          end else if (scl_fall) begin
            if (mack_q) begin
              sreg_d   = mem_rdata;
              oe_d     = !mem_rdata[DATA_W-1];
              ptr_step = 1'b1;
              cnt_d    = '0;
              state_d  = ST_RDATA;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end

    if (ptr_step) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nxt_q   <= NX_ADDR;
      cnt_q   <= '0;
      sreg_q  <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      nxt_q   <= nxt_d;
      cnt_q   <= cnt_d;
      sreg_q  <= sreg_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
  parameter int ADDR_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     scl_i,
  input logic                     sda_oe,
  input logic [ADDR_W-1:0]        ptr_q,
  input logic                     ptr_step,
  input logic                     start_det,
  input logic                     stop_det,
  input i2c_mem_pkg::tgt_state_e  state_q
);
  import i2c_mem_pkg::*;

  // R9: drive held through SCL high unless a bus condition released it
  a_r9_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R8: every pointer step is +1 modulo the memory depth
  a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

  // R10: a Start leaves the pointer untouched
  a_r10_start_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> $stable(ptr_q));

  // R10: a Stop releases SDA
  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R1: an ignored transfer never sees the target pull SDA
  a_r1_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !sda_oe);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .ptr_q     (ptr_q),
  .ptr_step  (ptr_step),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state_q   (state_q)
);

// File: tb/i2c_mem_target_test.sv
`timescale 1ns/1ps
module i2c_mem_target_test;
  localparam logic [7:0] CW = {7'h50, 1'b0};
  localparam logic [7:0] CR = {7'h50, 1'b1};
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h10_3C, 16'h11_C3, 16'h7F_01,
                                       16'h80_FE, 16'hFE_55, 16'h03_AA};

  logic clk, rst_n, m_scl, m_sda, sda_oe, sda_bus;
  int n_run, n_fail;
  logic [7:0] bm [256];
  logic [7:0] bptr;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_mem_target uut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; q(); m_scl = 1'b1; q(); m_scl = 1'b0; q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; q(); m_scl = 1'b1; q();
    ack = !sda_bus;
    m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      q(); m_scl = 1'b1; q(); b = {b[6:0], sda_bus}; m_scl = 1'b0;
    end
    q(); m_sda = !mack; q(); m_scl = 1'b1; q(); m_scl = 1'b0; q();
    m_sda = 1'b1;
  endtask

  task automatic write_run(input string tag, input logic [7:0] a, input logic [7:0] seed, input int n);
    logic ack;
    bus_start();
    send_byte(CW, ack); chk({tag, " R1 ctrl ack"}, 8'(ack), 8'd1);
    send_byte(a, ack);  chk({tag, " R2 addr ack"}, 8'(ack), 8'd1);
    bptr = a;
    for (int k = 0; k < n; k++) begin
      send_byte(8'(seed + 8'(k * 37)), ack);
      chk({tag, " R3 data ack"}, 8'(ack), 8'd1);
      bm[bptr] = 8'(seed + 8'(k * 37));
      bptr++;
    end
    bus_stop();
  endtask

  task automatic read_tail(input string tag, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(CR, ack); chk({tag, " R4 read ctrl ack"}, 8'(ack), 8'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk({tag, " R7 data"}, d, bm[bptr]);
      bptr++;
    end
    chk({tag, " R7 released after nack"}, 8'(sda_oe), 8'd0);
    bus_stop();
  endtask

  task automatic rand_read(input string tag, input logic [7:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(CW, ack);
    send_byte(a, ack); chk({tag, " R6 addr ack"}, 8'(ack), 8'd1);
    bptr = a;
    read_tail(tag, n);
  endtask

  initial begin
    n_run = 0; n_fail = 0; bptr = '0;
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("reset R9 sda released", 8'(sda_oe), 8'd0);
    rst_n = 1'b1;
    q();

    for (int v = 0; v < NV; v++) begin
      write_run("vec", VEC[v][15:8], VEC[v][7:0], 1);
      rand_read("vec R4", VEC[v][15:8], 1);
    end

    write_run("seq R3", 8'h20, 8'h11, 4);
    rand_read("seq R7", 8'h20, 4);
    read_tail("cur R5", 1);

    write_run("wrap R8 w", 8'hFE, 8'h90, 3);
    rand_read("wrap R8 r", 8'hFD, 4);
    bptr = 8'hFF;
    rand_read("wrap R8 single", 8'hFF, 1);
    read_tail("wrap R8 cur", 1);

    begin : bad_dev
      logic ack;
      bus_start();
      send_byte({7'h51, 1'b0}, ack); chk("R1 foreign ctrl no ack", 8'(ack), 8'd0);
      send_byte(8'h40, ack);         chk("R1 foreign addr no ack", 8'(ack), 8'd0);
      send_byte(8'h77, ack);
      bus_stop();
      read_tail("R1 pointer kept", 1);
    end

    write_run("abort prep", 8'h60, 8'h5E, 1);
    begin : abort_mid
      logic ack;
      bus_start();
      send_byte(CW, ack);
      send_byte(8'h60, ack);
      send_bits(8'hFF, 3);
      bus_stop();
      chk("R10 released after abort", 8'(sda_oe), 8'd0);
      bptr = 8'h60;
      read_tail("R10 no store", 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R7 actual=hang expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule